// File: doc/BRIEF.md
# Sensorless Three-Phase Spindle Commutation Sequencer

This block sequences the six-step drive of a three-phase spindle motor that has no position sensors. From standstill it forces commutation steps open-loop, paced by a slow start-up tick. After each step it blanks the floating phase's back-EMF comparator for a fixed number of cycles so that switching transients are not taken for zero crossings. Once several forced steps in a row have each seen a genuine crossing, it hands over to closed-loop operation, where every accepted crossing commutes the motor. If crossings stop arriving, it falls back to forced start-up.

A signed torque command, taken relative to a zero reference, selects the action. Above the dead zone the motor is driven forward. Inside the dead zone all phases float. Below the dead zone the motor is braked, either by shorting all phases low or by driving reverse torque, depending on a brake-select input. A PHASE output toggles on every accepted crossing. A soft-switching flag reports when the crossing rate is high enough for soft-switched drive.

The analog side is outside this block: filtering, gain control, current limiting and the power stage. The comparators arrive as plain digital levels.

Top module: `bldc_commutator`

States (`mode`): IDLE (0), SYNC (1, forced start-up), EMF (2, back-EMF tracking). Transitions: IDLE→SYNC on a forward command; SYNC→SYNC on each forced step; SYNC→EMF on lock; EMF→EMF on each accepted crossing; EMF→SYNC on timeout; any→IDLE when enable is low.

## Requirements
- R1: While `enable` is low, all three drives are float (code 00), `mode` is IDLE (0), PHASE is 0 and the soft flag is 0 from the next clock on. In IDLE every drive floats whatever the command.
- R2: In IDLE with `enable` high, a command above +DEAD moves to SYNC (1) at step 0. Forward drive (high=10, low=01) follows the step order (high,low) = (U,V),(U,W),(V,W),(V,U),(W,U),(W,V), then wraps to step 0; exactly one phase floats.
- R3: In SYNC, the step advances on the SYNC_TICKS-th tick counted since the last commutation.
- R4: After a commutation, the floating phase's comparator (cmp bit 0=U, 1=V, 2=W) is ignored for MASK_CYC+1 cycles. Its level is then latched as reference, and a crossing is the first later difference from that reference; at most one crossing is accepted per step.
- R5: PHASE toggles once per accepted crossing, and a crossing is accepted only while `emf_ok` is high.
- R6: In SYNC, when LOCK_STEPS consecutive forced steps have each accepted a crossing, the commutation ending the last of them enters EMF (2).
- R7: In EMF, each accepted crossing advances the step in the same clock.
- R8: In EMF, if TIMEOUT_TICKS ticks pass since the last commutation with no accepted crossing, the mode returns to SYNC and the step is kept.
- R9: A command within [-DEAD, +DEAD] floats all three phases while the sequencer keeps running.
- R10: A command below -DEAD with `brake_sel` low drives all three phases low.
- R11: A command below -DEAD with `brake_sel` high drives the current step with high and low exchanged.
- R12: The soft flag is 1 only in EMF, and only when the last two accepted crossings were fewer than SOFT_TICKS ticks apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable; low floats outputs and returns to IDLE |
| tick | input | 1 | One-cycle start-up period strobe |
| emf_cmp | input | 3 | Back-EMF comparator levels, bit 0 U, bit 1 V, bit 2 W |
| emf_ok | input | 1 | Back-EMF amplitude above detection threshold |
| torque_cmd | input | CMD_W | Signed torque command relative to reference |
| brake_sel | input | 1 | 0 short brake, 1 reverse-torque brake |
| drv_u | output | 2 | Phase U drive: 00 float, 01 low, 10 high |
| drv_v | output | 2 | Phase V drive, same coding |
| drv_w | output | 2 | Phase W drive, same coding |
| phase_out | output | 1 | Toggles on each accepted zero crossing |
| mode | output | 2 | 0 IDLE, 1 SYNC, 2 EMF |
| soft_sw | output | 1 | Soft-switching drive permitted |

## Verification
The bench builds the block with SYNC_TICKS=4, MASK_CYC=3, LOCK_STEPS=2, TIMEOUT_TICKS=6, SOFT_TICKS=3 and DEAD=8 on an 8-bit command. With these short windows, random comparator toggles readily complete lock, and they also often outlast the timeout. Within a short run this reaches handover to EMF, fallback to SYNC, comparator edges inside the blanking window, and both settings of the soft flag. Commands are drawn so that they land on the dead-zone boundaries ±8 and ±9, as well as in all four action classes.

// File: rtl/bldc_pkg.sv
package bldc_pkg;

    typedef enum logic [1:0] {
        DRV_FLOAT = 2'b00,
        DRV_LOW   = 2'b01,
        DRV_HIGH  = 2'b10
    } drv_e;

    typedef enum logic [1:0] {
        MODE_IDLE = 2'd0,
        MODE_SYNC = 2'd1,
        MODE_EMF  = 2'd2
    } mode_e;

    typedef enum logic [1:0] {
        ACT_COAST,
        ACT_FWD,
        ACT_SHORT,
        ACT_REVERSE
    } act_e;

    // Phase indices: 0 = U, 1 = V, 2 = W
    function automatic logic [1:0] high_of(input logic [2:0] step);
        unique case (step)
            3'd0, 3'd1: high_of = 2'd0;
            3'd2, 3'd3: high_of = 2'd1;
            default:    high_of = 2'd2;
        endcase
    endfunction

    function automatic logic [1:0] low_of(input logic [2:0] step);
        unique case (step)
            3'd0:       low_of = 2'd1;
            3'd1, 3'd2: low_of = 2'd2;
            3'd3, 3'd4: low_of = 2'd0;
            default:    low_of = 2'd1;
        endcase
    endfunction

    function automatic logic [1:0] float_of(input logic [2:0] step);
        float_of = 2'd3 - high_of(step) - low_of(step);
    endfunction

endpackage

// File: rtl/bldc_zc_watch.sv
module bldc_zc_watch #(
    parameter int MASK_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic flag,
    input  logic emf_ok,
    output logic hit
);
    localparam int MW = (MASK_CYC < 1) ? 1 : $clog2(MASK_CYC + 1);
    localparam logic [MW-1:0] MASK_LOAD = MW'(MASK_CYC);

    logic [MW-1:0] cnt_q;
    logic          armed_q;
    logic          spent_q;
    logic          ref_q;

    assign hit = armed_q && emf_ok && (flag != ref_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= MASK_LOAD;
            armed_q <= 1'b0;
            spent_q <= 1'b0;
            ref_q   <= 1'b0;
        end else if (clear) begin
            cnt_q   <= MASK_LOAD;
            armed_q <= 1'b0;
            spent_q <= 1'b0;
        end else if (hit) begin
            armed_q <= 1'b0;
            spent_q <= 1'b1;
        end else if (!armed_q && !spent_q) begin
            if (cnt_q == '0) begin
                armed_q <= 1'b1;
                ref_q   <= flag;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    // R4: the blanking window starts right after a commutation
    a_r4_quiet_after_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !hit);

    // R4: at most one accepted crossing per step
    a_r4_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> !hit);

endmodule

// File: rtl/bldc_drive_map.sv
module bldc_drive_map
    import bldc_pkg::*;
(
    input  logic           active,
    input  act_e           act,
    input  logic [2:0]     step,
    output logic [2:0][1:0] drv
);
    logic [1:0] hi_idx;
    logic [1:0] lo_idx;

    assign hi_idx = high_of(step);
    assign lo_idx = low_of(step);

    for (genvar p = 0; p < 3; p++) begin : g_phase
        drv_e ph;
        always_comb begin
            ph = DRV_FLOAT;
            if (active) begin
                unique case (act)
                    ACT_COAST:   ph = DRV_FLOAT;
                    ACT_SHORT:   ph = DRV_LOW;
                    ACT_FWD: begin
                        if (hi_idx == 2'(p))      ph = DRV_HIGH;
                        else if (lo_idx == 2'(p)) ph = DRV_LOW;
                    end
                    ACT_REVERSE: begin
                        if (hi_idx == 2'(p))      ph = DRV_LOW;
                        else if (lo_idx == 2'(p)) ph = DRV_HIGH;
                    end
                endcase
            end
        end
        assign drv[p] = ph;
    end

endmodule

// File: rtl/bldc_commutator.sv
module bldc_commutator
    import bldc_pkg::*;
#(
    parameter int CMD_W         = 8,
    parameter int DEAD          = 8,
    parameter int SYNC_TICKS    = 4,
    parameter int MASK_CYC      = 16,
    parameter int LOCK_STEPS    = 2,
    parameter int TIMEOUT_TICKS = 24,
    parameter int SOFT_TICKS    = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    enable,
    input  logic                    tick,
    input  logic [2:0]              emf_cmp,
    input  logic                    emf_ok,
    input  logic signed [CMD_W-1:0] torque_cmd,
    input  logic                    brake_sel,
    output logic [1:0]              drv_u,
    output logic [1:0]              drv_v,
    output logic [1:0]              drv_w,
    output logic                    phase_out,
    output logic [1:0]              mode,
    output logic                    soft_sw
);
    localparam int TMAX = (SYNC_TICKS > TIMEOUT_TICKS) ? SYNC_TICKS : TIMEOUT_TICKS;
    localparam int CW   = $clog2(TMAX + 1);
    localparam int LW   = $clog2(LOCK_STEPS + 1);
    localparam int GW   = $clog2(SOFT_TICKS + 1);
    localparam logic [CW-1:0] SYNC_LAST = CW'(SYNC_TICKS - 1);
    localparam logic [CW-1:0] TOUT_LAST = CW'(TIMEOUT_TICKS - 1);
    localparam logic [LW-1:0] LOCK_N    = LW'(LOCK_STEPS);
    localparam logic [GW-1:0] SOFT_N    = GW'(SOFT_TICKS);
    localparam logic signed [CMD_W-1:0] POS_DEAD = CMD_W'(DEAD);
    localparam logic signed [CMD_W-1:0] NEG_DEAD = CMD_W'(-DEAD);

    mode_e          state_q;
    logic [2:0]     step_q;
    logic [CW-1:0]  tcnt_q;
    logic [LW-1:0]  lock_q;
    logic           seen_q;
    logic           phase_q;
    logic [GW-1:0]  gap_q;
    logic           soft_q;

    act_e           act;
    logic           hit, com, tout, wclear;
    logic [LW-1:0]  lock_nxt;
    logic [2:0]     step_nxt;
    logic [2:0][1:0] drv;

    always_comb begin
        if (torque_cmd > POS_DEAD)      act = ACT_FWD;
        else if (torque_cmd < NEG_DEAD) act = brake_sel ? ACT_REVERSE : ACT_SHORT;
        else                            act = ACT_COAST;
    end

    assign com  = ((state_q == MODE_SYNC) && tick && (tcnt_q == SYNC_LAST))
               || ((state_q == MODE_EMF) && hit);
    assign tout = (state_q == MODE_EMF) && tick && (tcnt_q == TOUT_LAST) && !hit;
    assign wclear   = !enable || (state_q == MODE_IDLE) || com || tout;
    assign lock_nxt = (seen_q || hit) ? lock_q + 1'b1 : '0;
    assign step_nxt = (step_q == 3'd5) ? 3'd0 : step_q + 3'd1;

    bldc_zc_watch #(.MASK_CYC(MASK_CYC)) u_watch (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (wclear),
        .flag   (emf_cmp[float_of(step_q)]),
        .emf_ok (emf_ok),
        .hit    (hit)
    );

    bldc_drive_map u_map (
        .active (enable && (state_q != MODE_IDLE)),
        .act    (act),
        .step   (step_q),
        .drv    (drv)
    );

    // State register and sequencing
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= MODE_IDLE;
            step_q  <= 3'd0;
            tcnt_q  <= '0;
            lock_q  <= '0;
            seen_q  <= 1'b0;
        end else if (!enable) begin
            state_q <= MODE_IDLE;
            step_q  <= 3'd0;
            tcnt_q  <= '0;
            lock_q  <= '0;
            seen_q  <= 1'b0;
        end else begin
            unique case (state_q)
                MODE_IDLE: begin
                    if (act == ACT_FWD) begin
                        state_q <= MODE_SYNC;
                        step_q  <= 3'd0;
                        tcnt_q  <= '0;
                        lock_q  <= '0;
                        seen_q  <= 1'b0;
                    end
                end
                MODE_SYNC: begin
                    if (com) begin
                        step_q <= step_nxt;
                        tcnt_q <= '0;
                        seen_q <= 1'b0;
                        if (lock_nxt == LOCK_N) begin
                            state_q <= MODE_EMF;
                            lock_q  <= '0;
                        end else begin
                            lock_q <= lock_nxt;
                        end
                    end else begin
                        if (hit)  seen_q <= 1'b1;
                        if (tick) tcnt_q <= tcnt_q + 1'b1;
                    end
                end
                MODE_EMF: begin
                    if (hit) begin
                        step_q <= step_nxt;
                        tcnt_q <= '0;
                    end else if (tout) begin
                        state_q <= MODE_SYNC;
                        tcnt_q  <= '0;
                        lock_q  <= '0;
                        seen_q  <= 1'b0;
                    end else if (tick) begin
                        tcnt_q <= tcnt_q + 1'b1;
                    end
                end
                default: state_q <= MODE_IDLE;
            endcase
        end
    end

    // Crossing pulse output and rate measurement
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= 1'b0;
            gap_q   <= SOFT_N;
            soft_q  <= 1'b0;
        end else if (!enable) begin
            phase_q <= 1'b0;
            gap_q   <= SOFT_N;
            soft_q  <= 1'b0;
        end else if (hit) begin
            phase_q <= !phase_q;
            soft_q  <= (gap_q < SOFT_N);
            gap_q   <= '0;
        end else if (tick && (gap_q < SOFT_N)) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    // Outputs
    always_comb begin
        drv_u     = drv[0];
        drv_v     = drv[1];
        drv_w     = drv[2];
        mode      = state_q;
        phase_out = phase_q;
        soft_sw   = soft_q && (state_q == MODE_EMF);
    end

    a_r1_disable_idles: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (mode == MODE_IDLE) && !phase_out && !soft_sw);

    a_r2_one_float: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && (state_q != MODE_IDLE) && (act == ACT_FWD)) |->
        ($countones({drv_u == DRV_FLOAT, drv_v == DRV_FLOAT, drv_w == DRV_FLOAT}) == 1));

    a_r5_phase_only_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_out != $past(phase_out)) |-> ($past(hit) || !$past(enable)));

    a_r7_emf_hit_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && (state_q == MODE_EMF) && hit) |=> (step_q != $past(step_q)));

    a_r9_coast_floats: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_COAST) |->
        (drv_u == DRV_FLOAT) && (drv_v == DRV_FLOAT) && (drv_w == DRV_FLOAT));

    a_r10_short_low: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && (state_q != MODE_IDLE) && (act == ACT_SHORT)) |->
        (drv_u == DRV_LOW) && (drv_v == DRV_LOW) && (drv_w == DRV_LOW));

    a_r12_soft_only_emf: assert property (@(posedge clk) disable iff (!rst_n)
        soft_sw |-> (mode == MODE_EMF));

endmodule

// File: tb/bldc_commutator_test.sv
module bldc_commutator_test;
    localparam int CMD_W = 8, DEAD = 8, SYNC_TICKS = 4, MASK_CYC = 3;
    localparam int LOCK_STEPS = 2, TIMEOUT_TICKS = 6, SOFT_TICKS = 3;

    logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0, tick = 1'b0, emf_ok = 1'b0, brake_sel = 1'b0;
    logic [2:0] emf_cmp = 3'b000;
    logic signed [CMD_W-1:0] torque_cmd = '0;
    logic [1:0] drv_u, drv_v, drv_w, mode;
    logic phase_out, soft_sw;

    always #2 clk = ~clk;

    bldc_commutator #(.CMD_W(CMD_W), .DEAD(DEAD), .SYNC_TICKS(SYNC_TICKS),
        .MASK_CYC(MASK_CYC), .LOCK_STEPS(LOCK_STEPS),
        .TIMEOUT_TICKS(TIMEOUT_TICKS), .SOFT_TICKS(SOFT_TICKS)) uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .tick(tick), .emf_cmp(emf_cmp),
        .emf_ok(emf_ok), .torque_cmd(torque_cmd), .brake_sel(brake_sel),
        .drv_u(drv_u), .drv_v(drv_v), .drv_w(drv_w), .phase_out(phase_out),
        .mode(mode), .soft_sw(soft_sw));

    int checks = 0, fails = 0, cyc = 0;
    bit done = 0;
    int HI[6] = '{0, 0, 1, 1, 2, 2};
    int LO[6] = '{1, 2, 2, 0, 0, 1};

    // Behavioural model state
    int m_state, m_step, m_tcnt, m_lock, m_seen, m_phase, m_gap, m_soft;
    int m_cnt, m_armed, m_spent, m_ref;
    string t_mode, t_drv, t_ph;

    function automatic int flt(int s);
        return 3 - HI[s] - LO[s];
    endfunction

    function automatic int exp_drv(int p);
        int c;
        c = int'(torque_cmd);
        if (!enable || m_state == 0) return 0;
        if (c > DEAD) return (p == HI[m_step]) ? 2 : (p == LO[m_step]) ? 1 : 0;
        if (c < -DEAD) begin
            if (!brake_sel) return 1;
            return (p == HI[m_step]) ? 1 : (p == LO[m_step]) ? 2 : 0;
        end
        return 0;
    endfunction

    task automatic model_reset();
        m_state = 0; m_step = 0; m_tcnt = 0; m_lock = 0; m_seen = 0;
        m_phase = 0; m_gap = SOFT_TICKS; m_soft = 0;
        m_cnt = MASK_CYC; m_armed = 0; m_spent = 0; m_ref = 0;
    endtask

    task automatic model_next();
        int fl, hit, com, tout, clr, c, ln;
        t_mode = (m_state == 0) ? "R1" : "R2";
        t_drv = "R2";
        t_ph = "R5";
        if (!rst_n || !enable) begin
            model_reset();
            t_mode = "R1"; t_drv = "R1"; t_ph = "R1";
            return;
        end
        c = int'(torque_cmd);
        fl = emf_cmp[flt(m_step)];
        hit = m_armed && emf_ok && (fl != m_ref);
        com = (m_state == 1 && tick && m_tcnt == SYNC_TICKS - 1) || (m_state == 2 && hit);
        tout = (m_state == 2 && tick && m_tcnt == TIMEOUT_TICKS - 1 && !hit);
        clr = (m_state == 0) || com || tout;
        if (m_state != 0 && !m_armed && !m_spent) t_ph = "R4";
        // phase and rate
        if (hit) begin
            m_phase ^= 1; m_soft = (m_gap < SOFT_TICKS); m_gap = 0;
        end else if (tick && m_gap < SOFT_TICKS) m_gap++;
        // sequencer
        case (m_state)
            0: if (c > DEAD) begin m_state = 1; m_step = 0; m_tcnt = 0; m_lock = 0; m_seen = 0; end
            1: if (com) begin
                   t_drv = "R3";
                   ln = (m_seen || hit) ? m_lock + 1 : 0;
                   m_step = (m_step + 1) % 6; m_tcnt = 0; m_seen = 0;
                   if (ln == LOCK_STEPS) begin m_state = 2; m_lock = 0; t_mode = "R6"; end
                   else m_lock = ln;
               end else begin
                   if (hit) m_seen = 1;
                   if (tick) m_tcnt++;
               end
            default: if (hit) begin
                   m_step = (m_step + 1) % 6; m_tcnt = 0; t_drv = "R7";
               end else if (tout) begin
                   m_state = 1; m_tcnt = 0; m_lock = 0; m_seen = 0; t_mode = "R8";
               end else if (tick) m_tcnt++;
        endcase
        // blanking watch
        if (clr) begin m_cnt = MASK_CYC; m_armed = 0; m_spent = 0; end
        else if (hit) begin m_armed = 0; m_spent = 1; end
        else if (!m_armed && !m_spent) begin
            if (m_cnt == 0) begin m_armed = 1; m_ref = fl; end
            else m_cnt--;
        end
    endtask

    task automatic chk(string tag, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic cycle();
        int c;
        string dt;
        model_next();
        @(posedge clk);
        #1;
        cyc++;
        c = int'(torque_cmd);
        dt = t_drv;
        if (enable && m_state != 0) begin
            if (c < -DEAD) dt = brake_sel ? "R11" : "R10";
            else if (c <= DEAD) dt = "R9";
        end
        chk(dt, int'(drv_u), exp_drv(0), "drv_u");
        chk(dt, int'(drv_v), exp_drv(1), "drv_v");
        chk(dt, int'(drv_w), exp_drv(2), "drv_w");
        chk(t_mode, int'(mode), m_state, "mode");
        chk(t_ph, int'(phase_out), m_phase, "phase_out");
        chk("R12", int'(soft_sw), (m_soft && m_state == 2) ? 1 : 0, "soft_sw");
    endtask

    function automatic logic signed [CMD_W-1:0] pick_cmd();
        int r;
        r = $urandom_range(0, 99);
        if (r < 55) return CMD_W'($urandom_range(DEAD + 1, 127));
        if (r < 60) return CMD_W'(DEAD + 1);
        if (r < 65) return CMD_W'(DEAD);
        if (r < 70) return CMD_W'(-DEAD);
        if (r < 75) return CMD_W'(-DEAD - 1);
        if (r < 80) return CMD_W'(int'($urandom_range(0, 2 * DEAD)) - DEAD);
        return CMD_W'(-int'($urandom_range(DEAD + 1, 128)));
    endfunction

    initial begin
        #(4 * 190000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        // R1: reset state
        repeat (3) cycle();
        rst_n = 1'b1;
        repeat (2) cycle();
        // R1: enabled but idle with brake command still floats
        enable = 1'b1; torque_cmd = CMD_W'(-40); brake_sel = 1'b1;
        repeat (3) cycle();
        // R2: forward start, then R10/R11 brakes and R9 coast in SYNC
        torque_cmd = CMD_W'(50); emf_ok = 1'b1;
        repeat (3) cycle();
        torque_cmd = CMD_W'(-30); brake_sel = 1'b0; cycle();
        brake_sel = 1'b1; cycle();
        torque_cmd = CMD_W'(DEAD); cycle();
        torque_cmd = CMD_W'(50);
        // Mixed random phase
        for (int i = 0; i < 40000; i++) begin
            tick = ($urandom_range(0, 2) == 0);
            for (int b = 0; b < 3; b++)
                if ($urandom_range(0, 5) == 0) emf_cmp[b] = ~emf_cmp[b];
            emf_ok = ($urandom_range(0, 9) != 0);
            if ($urandom_range(0, 39) == 0) torque_cmd = pick_cmd();
            if ($urandom_range(0, 59) == 0) brake_sel = ~brake_sel;
            if ($urandom_range(0, 499) == 0) enable = 1'b0;
            else if (!enable && $urandom_range(0, 3) == 0) enable = 1'b1;
            cycle();
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule